// File: doc/BRIEF.md
# Interrupt Status Aggregation Register Bank

The block gathers twenty-four single-bit event inputs from peripheral modules into three byte-wide status registers and raises one interrupt line toward a host processor. Each event input is edge-captured: a rising edge sets its status bit, and the bit stays set until software clears it. Two separate mask layers apply, both active-high. A status-mask bit stops its source from being latched at all. A line-mask bit leaves the status bit visible but keeps it from driving the interrupt line.

Software reaches the nine registers through a plain byte-wide parallel port. The three status bytes sit at consecutive addresses, and so does each group of three mask bytes, so a three-byte burst walks a whole group in order. A write of any value to any status byte clears all twenty-four status bits at once. An event edge that lands in the same cycle as that write still survives the clear.

Top module: `irqagg_top`

## Requirements
- R1: After reset, all six mask registers read 0xFF, all three status registers read 0x00, and `irq_out` is low.
- R2: An event bit n whose status-mask bit is 0 sets its status bit on the clock edge where `evt_in[n]` is first sampled high. The bit stays set after the input falls, until a clear.
- R3: An input held high sets its status bit only once. After a clear it does not set again until it has gone low and risen again.
- R4: Event bit n appears in status byte n/8 at bit n%8. The address map is: status bytes at 0,1,2; line-mask bytes at 4,5,6; status-mask bytes at 8,9,10. The lowest address of each group holds bits 7..0.
- R5: `irq_out` is registered. It goes high one clock after some status bit is set whose line-mask bit is 0, and it is low when no such bit exists.
- R6: A line-mask bit of 1 does not stop the status bit from being captured and read. It only keeps that bit off `irq_out`.
- R7: A write of any data to any of addresses 0, 1 or 2 clears all three status bytes in the same clock edge. `irq_out` then falls one clock later.
- R8: A new unmasked rising edge in the same cycle as a clearing write leaves its status bit set. Every other status bit is cleared.
- R9: A write to a status address never sets a status bit.
- R10: A write to a mask address changes only that byte, and the value reads back at the same address.
- R11: Event bits 12 and 23 are reserved. They never set, even when unmasked, and always read as 0.
- R12: Addresses outside the map (3, 7, 11 to 15) read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | 24 | Event sources, synchronous to `clk` |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe for one byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt line to the host, active high |

## Verification
Two things can land in the same clock edge: a clearing write to a status byte and a fresh rising edge on an unmasked event input. The bench sets up this collision on purpose. It first sets an unrelated status bit, then drives the clear strobe and the new event edge in the same cycle. It then reads back all three status bytes and expects only the new event's bit to remain. The checker also watches every clearing write: when no unmasked edge comes with it, the status must be zero afterwards, and when an edge does come with it, that edge's bits must be set afterwards.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_STS  = 2'd1,
      RGN_LMSK = 2'd2,
      RGN_SMSK = 2'd3
   } irqagg_rgn_e;

   // which register group an address falls into
   function automatic irqagg_rgn_e rgn_of(input int addr, input int sts_base,
                                          input int lmsk_base, input int smsk_base,
                                          input int nbytes);
      if (addr >= sts_base && addr < sts_base + nbytes)   return RGN_STS;
      if (addr >= lmsk_base && addr < lmsk_base + nbytes) return RGN_LMSK;
      if (addr >= smsk_base && addr < smsk_base + nbytes) return RGN_SMSK;
      return RGN_NONE;
   endfunction

endpackage

// File: rtl/irqagg_edge.sv
module irqagg_edge #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/irqagg_maskbank.sv
module irqagg_maskbank #(
   parameter int              NUM_BYTES = 3,
   parameter int              BYTE_W    = 8,
   parameter logic [BYTE_W-1:0] RST_VAL = '1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BYTES-1:0]        wr_sel,
   input  logic [BYTE_W-1:0]           wdata,
   output logic [NUM_BYTES*BYTE_W-1:0] word
);
   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      logic [BYTE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)        q <= RST_VAL;
         else if (wr_sel[i]) q <= wdata;
      end
      assign word[i*BYTE_W +: BYTE_W] = q;
   end
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
   parameter int         W    = 24,
   parameter logic [W-1:0] RSVD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic         clr,
   output logic [W-1:0] word
);
   logic [W-1:0] set_ok;
   assign set_ok = set_vec & ~RSVD;

   always_ff @(posedge clk) begin
      if (!rst_n)   word <= '0;
      else if (clr) word <= set_ok;          // a fresh edge survives the clear
      else          word <= word | set_ok;
   end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int NUM_BYTES = 3,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int STS_BASE  = 0,
   parameter int LMSK_BASE = 4,
   parameter int SMSK_BASE = 8,
   parameter logic [NUM_BYTES*BYTE_W-1:0] RSVD_BITS = 24'h80_1000,
   parameter logic [BYTE_W-1:0] MASK_RST = '1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_BYTES*BYTE_W-1:0] evt_in,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic                        reg_wr,
   input  logic [BYTE_W-1:0]           reg_wdata,
   output logic [BYTE_W-1:0]           reg_rdata,
   output logic                        irq_out
);
   localparam int W_TOTAL = NUM_BYTES * BYTE_W;
   localparam int N_ADDR  = 2 ** ADDR_W;

   if (STS_BASE + NUM_BYTES > LMSK_BASE || LMSK_BASE + NUM_BYTES > SMSK_BASE) begin : g_bad_order
      $error("irqagg_top: register groups overlap or are out of order");
   end
   if (SMSK_BASE + NUM_BYTES > N_ADDR) begin : g_bad_span
      $error("irqagg_top: address width too small for register map");
   end

   logic [NUM_BYTES-1:0] hit_sts, hit_lmsk, hit_smsk;
   logic [W_TOTAL-1:0]   rise_vec, sts_word, lmask_word, smask_word;
   logic                 sts_clr, irq_q;
   irqagg_rgn_e          rgn;

   assign rgn = rgn_of(int'(reg_addr), STS_BASE, LMSK_BASE, SMSK_BASE, NUM_BYTES);

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_dec
      assign hit_sts[i]  = (reg_addr == ADDR_W'(STS_BASE + i));
      assign hit_lmsk[i] = (reg_addr == ADDR_W'(LMSK_BASE + i));
      assign hit_smsk[i] = (reg_addr == ADDR_W'(SMSK_BASE + i));
   end

   assign sts_clr = reg_wr && (rgn == RGN_STS);

   irqagg_edge #(.W(W_TOTAL)) u_edge (
      .clk (clk), .rst_n (rst_n), .lvl (evt_in), .rise (rise_vec)
   );

   irqagg_maskbank #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .RST_VAL(MASK_RST)) u_lmask (
      .clk (clk), .rst_n (rst_n), .wr_sel (hit_lmsk & {NUM_BYTES{reg_wr}}),
      .wdata (reg_wdata), .word (lmask_word)
   );

   irqagg_maskbank #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .RST_VAL(MASK_RST)) u_smask (
      .clk (clk), .rst_n (rst_n), .wr_sel (hit_smsk & {NUM_BYTES{reg_wr}}),
      .wdata (reg_wdata), .word (smask_word)
   );

   irqagg_status #(.W(W_TOTAL), .RSVD(RSVD_BITS)) u_sts (
      .clk (clk), .rst_n (rst_n), .set_vec (rise_vec & ~smask_word),
      .clr (sts_clr), .word (sts_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(sts_word & ~lmask_word);
   end
   assign irq_out = irq_q;

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_BYTES; i++) begin
         if (hit_sts[i])  reg_rdata = sts_word[i*BYTE_W +: BYTE_W];
         if (hit_lmsk[i]) reg_rdata = lmask_word[i*BYTE_W +: BYTE_W];
         if (hit_smsk[i]) reg_rdata = smask_word[i*BYTE_W +: BYTE_W];
      end
   end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
   parameter int NUM_BYTES = 3,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int STS_BASE  = 0,
   parameter logic [NUM_BYTES*BYTE_W-1:0] RSVD_BITS = 24'h80_1000
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_BYTES*BYTE_W-1:0] evt_in,
   input logic [ADDR_W-1:0]           reg_addr,
   input logic                        reg_wr,
   input logic [NUM_BYTES*BYTE_W-1:0] status,
   input logic [NUM_BYTES*BYTE_W-1:0] lmask,
   input logic [NUM_BYTES*BYTE_W-1:0] smask,
   input logic                        irq_out
);
   localparam int W = NUM_BYTES * BYTE_W;

   logic [W-1:0] prev_evt, live_rise;
   logic         sts_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_evt <= '0;
      else        prev_evt <= evt_in;
   end

   assign live_rise = evt_in & ~prev_evt & ~smask & ~RSVD_BITS;
   assign sts_wr    = reg_wr && (int'(reg_addr) >= STS_BASE) &&
                      (int'(reg_addr) < STS_BASE + NUM_BYTES);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (irq_out == 1'b0 && status == '0));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sts_wr |=> ((~status & $past(status)) == '0));

   assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ($past(status & ~lmask) != '0));

   assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && live_rise == '0) |=> (status == '0));

   assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && live_rise != '0) |=> ((status & $past(live_rise)) == $past(live_rise)));

   assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (live_rise == '0) |=> ((status & ~$past(status)) == '0));

   assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (status & RSVD_BITS) == '0);
endmodule

bind irqagg_top irqagg_chk #(
   .NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
   .STS_BASE(STS_BASE), .RSVD_BITS(RSVD_BITS)
) u_chk (
   .clk (clk), .rst_n (rst_n), .evt_in (evt_in), .reg_addr (reg_addr),
   .reg_wr (reg_wr), .status (sts_word), .lmask (lmask_word),
   .smask (smask_word), .irq_out (irq_out)
);

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] evt_in = '0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;   // 125 MHz

   irqagg_top uut (
      .clk (clk), .rst_n (rst_n), .evt_in (evt_in), .reg_addr (reg_addr),
      .reg_wr (reg_wr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .irq_out (irq_out)
   );

   // {status-mask, line-mask, event pulse, expected status, expected irq}
   localparam logic [96:0] VEC [0:5] = '{
      {24'h00_0000, 24'h00_0000, 24'h00_0001, 24'h00_0001, 1'b1},
      {24'hFF_FFFF, 24'h00_0000, 24'h0F_0F0F, 24'h00_0000, 1'b0},
      {24'h00_0000, 24'hFF_FFFF, 24'h00_A5A5, 24'h00_A5A5, 1'b0},
      {24'h00_0000, 24'h00_0000, 24'hFF_FFFF, 24'h7F_EFFF, 1'b1},
      {24'h00_FF00, 24'h00_FFFF, 24'h12_3456, 24'h12_0056, 1'b1},
      {24'h80_0001, 24'hFF_FFFE, 24'h80_0001, 24'h00_0000, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic rd_sts(output logic [23:0] s);
      logic [7:0] b0, b1, b2;
      rd(4'd0, b0); rd(4'd1, b1); rd(4'd2, b2);
      s = {b2, b1, b0};
   endtask

   task automatic pulse(input logic [23:0] p);
      @(negedge clk); evt_in = p;
      @(negedge clk); evt_in = '0;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0]  b;
      logic [23:0] s;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 4; a <= 10; a++) begin
         if (a == 7) continue;
         rd(a[3:0], b); check("R1 mask reset", b, 8'hFF);
      end
      rd_sts(s); check("R1 status reset", s, 24'h0);
      check("R1 irq reset", irq_out, 1'b0);

      // R12 unmapped reads and writes
      rd(4'd3, b);  check("R12 read addr 3", b, 8'h00);
      rd(4'd15, b); check("R12 read addr 15", b, 8'h00);
      wr(4'd7, 8'h00);
      wr(4'd11, 8'h00);
      rd(4'd6, b);  check("R12 lmask after stray write", b, 8'hFF);
      rd(4'd10, b); check("R12 smask after stray write", b, 8'hFF);

      // table walk: R2 R4 R6 R11 R5
      foreach (VEC[k]) begin
         logic [23:0] sm, lm, ev, ex;
         logic        ei;
         {sm, lm, ev, ex, ei} = VEC[k];
         for (int i = 0; i < 3; i++) wr(4'(8 + i), sm[i*8 +: 8]);
         for (int i = 0; i < 3; i++) wr(4'(4 + i), lm[i*8 +: 8]);
         wr(4'd0, 8'h00);
         pulse(ev);
         @(negedge clk);
         rd(4'd0, b); check($sformatf("R4 R2 vec%0d byte0", k), b, ex[7:0]);
         rd(4'd1, b); check($sformatf("R4 R11 vec%0d byte1", k), b, ex[15:8]);
         rd(4'd2, b); check($sformatf("R4 R6 vec%0d byte2", k), b, ex[23:16]);
         check($sformatf("R5 vec%0d irq", k), irq_out, ei);
      end

      // all sources enabled for directed tests
      for (int i = 0; i < 3; i++) wr(4'(8 + i), 8'h00);
      for (int i = 0; i < 3; i++) wr(4'(4 + i), 8'h00);
      wr(4'd1, 8'h00);
      @(negedge clk);

      // R5 timing: status first, irq one clock later
      @(negedge clk); evt_in = 24'h00_0004;
      @(negedge clk); evt_in = '0;
      rd_sts(s); check("R5 status set", s, 24'h00_0004);
      check("R5 irq not yet", irq_out, 1'b0);
      @(negedge clk);
      check("R5 irq raised", irq_out, 1'b1);

      // R7 clear with arbitrary data on the last status byte
      wr(4'd2, 8'h5A);
      rd_sts(s); check("R7 all cleared", s, 24'h0);
      @(negedge clk);
      check("R7 irq dropped", irq_out, 1'b0);

      // R3 level held high sets once
      @(negedge clk); evt_in = 24'h00_0020;
      repeat (3) @(negedge clk);
      wr(4'd0, 8'h00);
      repeat (2) @(negedge clk);
      rd_sts(s); check("R3 held level no re-set", s, 24'h0);
      evt_in = '0;
      pulse(24'h00_0020);
      rd_sts(s); check("R3 fresh edge sets", s, 24'h00_0020);

      // R8 event edge in same cycle as clear
      @(negedge clk);
      reg_addr = 4'd1; reg_wdata = 8'hFF; reg_wr = 1'b1; evt_in = 24'h10_0000;
      @(negedge clk);
      reg_wr = 1'b0; evt_in = '0;
      rd_sts(s); check("R8 new event survives clear", s, 24'h10_0000);

      // R9 status write never sets
      wr(4'd0, 8'hFF);
      wr(4'd1, 8'hFF);
      rd_sts(s); check("R9 status stays zero", s, 24'h0);

      // R10 single mask byte update
      wr(4'd5, 8'h3C);
      rd(4'd4, b); check("R10 lmask byte0 untouched", b, 8'h00);
      rd(4'd5, b); check("R10 lmask byte1 written", b, 8'h3C);
      rd(4'd6, b); check("R10 lmask byte2 untouched", b, 8'h00);
      rd(4'd9, b); check("R10 smask byte1 untouched", b, 8'h00);

      // R11 reserved bits with everything unmasked
      pulse(24'h80_1000);
      rd_sts(s); check("R11 reserved stay zero", s, 24'h0);

      finish_run();
   end
endmodule